// File: doc/BRIEF.md
# Bit-Serial Interrupt Arbitration

This block decides which source answers an interrupt acknowledge when several sources hold a request at the acknowledged priority level. Each source has a 4-bit arbitration identifier stored in the block. Source slot 0 belongs to the system integration logic. Its identifier resets to all ones, and the identifiers of all other slots reset to zero. Requests from the external interrupt pins also compete through slot 0, so they use that slot's identifier.

When an acknowledge arrives, the block takes a snapshot of the eligible sources and their identifiers. It then runs a contention, one identifier bit per clock, starting at the most significant bit. In each cycle the eligible sources drive their current bit onto a wired-OR line. A source that drives 0 while the line reads 1 drops out. This contention runs on every acknowledge, even when only one source is requesting. When all bits have been processed, the block reports either a winner index or a spurious-interrupt result.

Top module: `irq_contend_arb`

## Requirements
- R1: After reset, slot 0 holds identifier 4'b1111 and every other slot holds 4'b0000. `busy`, `done`, `win_valid`, `spurious`, `win_ext` and `dup_id` are 0.
- R2: A slot is eligible when its 3-bit request level equals `ack_lvl` and `ack_lvl` is non-zero. Level 0 means no request. Levels are sampled only in the cycle the acknowledge is accepted.
- R3: Among the eligible slots, the one with the numerically highest identifier wins. `win_idx` reports its slot number.
- R4: An acknowledge is accepted when `ack_valid` is 1 and `busy` is 0. `done` is high in the cycle that follows the fourth rising edge after acceptance. This holds for any number of requesters, including one.
- R5: `spurious` is 1 and `win_valid` is 0 in two cases: when no slot is eligible, and when every eligible slot has identifier 0. In all other cases `win_valid` is 1 and `spurious` is 0.
- R6: An external request at `ext_lvl` makes slot 0 eligible with slot 0's identifier. `win_ext` is 1 only when slot 0 wins and slot 0 became eligible through the external request alone.
- R7: If two eligible slots share a non-zero identifier, `dup_id` is 1 with the result. The lowest-numbered of the tied slots wins.
- R8: `ack_valid` is ignored while `busy` is 1. Such an acknowledge neither changes the pending result nor starts a second contention.
- R9: A write with `id_wr_en`, `id_wr_sel` and `id_wr_val` replaces that slot's identifier from the next cycle onward.
- R10: `done` is a one-cycle pulse. The result outputs hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_wr_en | input | 1 | Identifier write strobe |
| id_wr_sel | input | SEL_W | Slot to write |
| id_wr_val | input | ID_W | New identifier |
| req_lvl | input | N_SRC*LVL_W | Request level per slot; slot i uses bits [i*LVL_W +: LVL_W] |
| ext_lvl | input | LVL_W | External pin request level, competing as slot 0 |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_lvl | input | LVL_W | Priority level being acknowledged |
| busy | output | 1 | Contention in progress |
| done | output | 1 | Result pulse |
| win_valid | output | 1 | A winner was found |
| spurious | output | 1 | No valid participant |
| win_idx | output | SEL_W | Winning slot |
| win_ext | output | 1 | Winner is the external request |
| dup_id | output | 1 | Eligible slots shared a non-zero identifier |

## Verification
The bench sweeps hundreds of pseudo-random identifier and level mixes. It weights the mix toward zero identifiers and toward ties, so that the following faults show up:
- A design that skips contention for a lone requester would finish early.
- A design that lets a zero identifier win would report a winner instead of a spurious result.
- A design that resolves ties toward the higher slot would return the wrong index.

Further directed cases cover two more faults. An acknowledge issued mid-contention, with changed levels, catches a design that restarts or resamples. A lone external request catches a design that marks internal wins as external or ignores the pins.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_id_bank.sv
module arb_id_bank #(
    parameter int N_SRC = 4,
    parameter int ID_W  = 4,
    parameter int SEL_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [ID_W-1:0]        wr_val,
    output logic [N_SRC*ID_W-1:0]  ids_o
);
    localparam int TOT = N_SRC * ID_W;
    localparam logic [TOT-1:0] RST_VAL = {{(TOT-ID_W){1'b0}}, {ID_W{1'b1}}};

    logic [TOT-1:0] ids_d, ids_q;

    always_comb begin
        ids_d = ids_q;
        for (int i = 0; i < N_SRC; i++) begin
            if (wr_en && (int'(wr_sel) == i)) begin
                ids_d[i*ID_W +: ID_W] = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ids_q <= RST_VAL;
        end else begin
            ids_q <= ids_d;
        end
    end

    assign ids_o = ids_q;

    // R9: a write lands in the selected slot on the next cycle
    p_id_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ids_q[int'($past(wr_sel))*ID_W +: ID_W] == $past(wr_val)));
endmodule

// File: rtl/arb_lane.sv
module arb_lane #(
    parameter int ID_W  = 4,
    parameter int BIT_W = 2
) (
    input  logic              alive_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic              line_i,
    output logic              drive_o,
    output logic              keep_o
);
    logic cur_bit;

    always_comb begin
        cur_bit = id_i[bit_i];
        drive_o = alive_i & cur_bit;
        keep_o  = alive_i & ~(line_i & ~cur_bit);
    end

    // R3: a lane driving 1 is never knocked out
    p_driver_stays_r3: assert final (!(drive_o && !keep_o));
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] vec_i,
    output logic [SEL_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |vec_i;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_contend_arb.sv
module irq_contend_arb #(
    parameter int N_SRC = 4,
    parameter int ID_W  = 4,
    parameter int LVL_W = 3,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    id_wr_en,
    input  logic [SEL_W-1:0]        id_wr_sel,
    input  logic [ID_W-1:0]         id_wr_val,
    input  logic [N_SRC*LVL_W-1:0]  req_lvl,
    input  logic [LVL_W-1:0]        ext_lvl,
    input  logic                    ack_valid,
    input  logic [LVL_W-1:0]        ack_lvl,
    output logic                    busy,
    output logic                    done,
    output logic                    win_valid,
    output logic                    spurious,
    output logic [SEL_W-1:0]        win_idx,
    output logic                    win_ext,
    output logic                    dup_id
);
    import arb_pkg::*;

    localparam int BIT_W = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(ID_W - 1);

    typedef struct packed {
        arb_state_e              st;
        logic [BIT_W-1:0]        bitp;
        logic [N_SRC-1:0]        alive;
        logic [N_SRC*ID_W-1:0]   ids;
        logic                    ext_only;
        logic                    dup;
        logic                    seen;
        logic                    done;
        logic                    win_valid;
        logic                    spurious;
        logic [SEL_W-1:0]        win_idx;
        logic                    win_ext;
        logic                    dup_out;
    } state_t;

    state_t q_q, q_d;

    logic [N_SRC*ID_W-1:0] ids_live;
    logic [N_SRC-1:0]      drive;
    logic [N_SRC-1:0]      keep;
    logic                  line;
    logic [SEL_W-1:0]      pick_idx;
    logic                  pick_any;
    logic [N_SRC-1:0]      elig;
    logic                  sim0_hit;
    logic                  ext_hit;
    logic                  dup_now;
    logic                  last_bit;
    logic                  any_one;

    arb_id_bank #(.N_SRC(N_SRC), .ID_W(ID_W), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (id_wr_en),
        .wr_sel (id_wr_sel),
        .wr_val (id_wr_val),
        .ids_o  (ids_live)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_lane
        arb_lane #(.ID_W(ID_W), .BIT_W(BIT_W)) u_lane (
            .alive_i (q_q.alive[g]),
            .id_i    (q_q.ids[g*ID_W +: ID_W]),
            .bit_i   (q_q.bitp),
            .line_i  (line),
            .drive_o (drive[g]),
            .keep_o  (keep[g])
        );
    end

    assign line = |drive;

    arb_pick #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_pick (
        .vec_i (keep),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    // eligibility and duplicate detection on the live request inputs
    always_comb begin
        elig = '0;
        for (int i = 0; i < N_SRC; i++) begin
            elig[i] = (ack_lvl != '0) && (req_lvl[i*LVL_W +: LVL_W] == ack_lvl);
        end
        sim0_hit = elig[0];
        ext_hit  = (ack_lvl != '0) && (ext_lvl == ack_lvl);
        elig[0]  = elig[0] | ext_hit;
        dup_now  = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            for (int j = i + 1; j < N_SRC; j++) begin
                if (elig[i] && elig[j]
                    && (ids_live[i*ID_W +: ID_W] == ids_live[j*ID_W +: ID_W])
                    && (ids_live[i*ID_W +: ID_W] != '0)) begin
                    dup_now = 1'b1;
                end
            end
        end
    end

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        last_bit = (q_q.bitp == '0);
        any_one  = q_q.seen | line;
        unique case (q_q.st)
            ST_IDLE: begin
                if (ack_valid) begin
                    q_d.st       = ST_RUN;
                    q_d.bitp     = TOP_BIT;
                    q_d.alive    = elig;
                    q_d.ids      = ids_live;
                    q_d.ext_only = ext_hit & ~sim0_hit;
                    q_d.dup      = dup_now;
                    q_d.seen     = 1'b0;
                end
            end
            ST_RUN: begin
                q_d.alive = keep;
                q_d.seen  = any_one;
                if (last_bit) begin
                    q_d.st        = ST_IDLE;
                    q_d.done      = 1'b1;
                    q_d.win_valid = pick_any & any_one;
                    q_d.spurious  = ~(pick_any & any_one);
                    q_d.win_idx   = (pick_any & any_one) ? pick_idx : '0;
                    q_d.win_ext   = pick_any & any_one & (pick_idx == '0) & q_q.ext_only;
                    q_d.dup_out   = q_q.dup;
                end else begin
                    q_d.bitp = q_q.bitp - 1'b1;
                end
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign busy      = (q_q.st == ST_RUN);
    assign done      = q_q.done;
    assign win_valid = q_q.win_valid;
    assign spurious  = q_q.spurious;
    assign win_idx   = q_q.win_idx;
    assign win_ext   = q_q.win_ext;
    assign dup_id    = q_q.dup_out;

    // R10: result strobe lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: results hold between strobes
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(win_idx) && $stable(win_valid) && $stable(spurious)));
    // R5: exactly one outcome is reported
    p_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (win_valid ^ spurious));
    // R4: the final bit is always followed by the strobe
    p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_bit) |=> (done && !busy));
    // R8: a running contention is not restarted
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_bit) |=> busy);
    // R7: without a shared identifier at most one survivor remains
    p_unique_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_bit && !q_q.dup && any_one) |-> $onehot0(keep));
    // R6: an external win is always reported as slot 0
    p_ext_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_ext |-> (win_valid && win_idx == '0));
endmodule

// File: tb/tb_irq_contend_arb.sv
module tb_irq_contend_arb;
    localparam int N = 4;
    localparam int IW = 4;
    localparam int LW = 3;
    localparam int SW = 2;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_wr_en = 1'b0;
    logic [SW-1:0] id_wr_sel = '0;
    logic [IW-1:0] id_wr_val = '0;
    logic [N*LW-1:0] req_lvl = '0;
    logic [LW-1:0] ext_lvl = '0;
    logic ack_valid = 1'b0;
    logic [LW-1:0] ack_lvl = '0;
    logic busy, done, win_valid, spurious, win_ext, dup_id;
    logic [SW-1:0] win_idx;

    int total = 0;
    int bad = 0;
    int unsigned seed = 32'h1234_5678;
    logic [IW-1:0] id_m [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_contend_arb #(.N_SRC(N), .ID_W(IW), .LVL_W(LW), .SEL_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .id_wr_en(id_wr_en), .id_wr_sel(id_wr_sel),
        .id_wr_val(id_wr_val), .req_lvl(req_lvl), .ext_lvl(ext_lvl),
        .ack_valid(ack_valid), .ack_lvl(ack_lvl), .busy(busy), .done(done),
        .win_valid(win_valid), .spurious(spurious), .win_idx(win_idx),
        .win_ext(win_ext), .dup_id(dup_id)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 16;
    endfunction

    task automatic write_id(input int sel, input logic [IW-1:0] val);
        @(negedge clk);
        id_wr_en = 1'b1; id_wr_sel = SW'(sel); id_wr_val = val;
        @(negedge clk);
        id_wr_en = 1'b0;
        id_m[sel] = val;
    endtask

    // drive one acknowledge, clear inputs after capture, measure latency
    task automatic run_ack(input logic [N*LW-1:0] lv, input logic [LW-1:0] ev,
                           input logic [LW-1:0] al, input bit poke, output int lat);
        @(negedge clk);
        req_lvl = lv; ext_lvl = ev; ack_lvl = al; ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0; req_lvl = '0; ext_lvl = '0;
        lat = 0;
        if (poke) begin
            // R8: a second acknowledge with a different picture while busy
            req_lvl = {N{3'd5}}; ack_lvl = 3'd5; ack_valid = 1'b1;
        end
        while (!done && lat < 20) begin
            @(negedge clk);
            ack_valid = 1'b0;
            lat++;
        end
        req_lvl = '0;
    endtask

    task automatic check_case(input logic [N*LW-1:0] lv, input logic [LW-1:0] ev,
                              input logic [LW-1:0] al, input bit poke);
        int lat;
        bit el [N];
        bit sim0, ext0, exp_dup, exp_valid;
        int best, widx;
        sim0 = (al != 0) && (lv[0 +: LW] == al);
        ext0 = (al != 0) && (ev == al);
        for (int i = 0; i < N; i++) el[i] = (al != 0) && (lv[i*LW +: LW] == al);
        el[0] = el[0] | ext0;
        best = 0; widx = 0; exp_dup = 0;
        for (int i = 0; i < N; i++) begin
            if (el[i] && int'(id_m[i]) > best) begin best = int'(id_m[i]); widx = i; end
            for (int j = i + 1; j < N; j++)
                if (el[i] && el[j] && id_m[i] == id_m[j] && id_m[i] != 0) exp_dup = 1;
        end
        exp_valid = (best != 0);
        run_ack(lv, ev, al, poke, lat);
        check("R4 latency", lat, 4);
        check("R5 win_valid", int'(win_valid), int'(exp_valid));
        check("R5 spurious", int'(spurious), int'(!exp_valid));
        if (exp_valid) check("R3 winner", int'(win_idx), widx);
        check("R6 win_ext", int'(win_ext), int'(exp_valid && widx == 0 && ext0 && !sim0));
        check("R7 dup_id", int'(dup_id), int'(exp_dup));
        @(negedge clk);
        check("R10 done pulse", int'(done), 0);
        if (exp_valid) check("R10 hold", int'(win_idx), widx);
        if (poke) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                check("R8 no second result", int'(done), 0);
            end
            check("R8 result kept", int'(win_valid), int'(exp_valid));
        end
    endtask

    function automatic logic [N*LW-1:0] lv4(input int a, input int b, input int c, input int d);
        return {LW'(d), LW'(c), LW'(b), LW'(a)};
    endfunction

    initial begin
        id_m[0] = '1;
        for (int i = 1; i < N; i++) id_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 win_valid", int'(win_valid), 0);
        check("R1 spurious", int'(spurious), 0);
        check("R1 dup_id", int'(dup_id), 0);
        // R1 reset identifiers: slot 0 wins over reset-zero slots; zeros alone are spurious
        check_case(lv4(2, 2, 2, 2), 3'd0, 3'd2, 1'b0);
        check("R1 slot0 wins", int'(win_idx), 0);
        check_case(lv4(0, 4, 4, 0), 3'd0, 3'd4, 1'b0);
        check("R1 zero ids spurious", int'(spurious), 1);
        // R2 no eligible slot, and ack level 0
        check_case(lv4(1, 1, 1, 1), 3'd0, 3'd6, 1'b0);
        check_case(lv4(0, 0, 0, 0), 3'd0, 3'd0, 1'b0);
        // R9 writes then R3 single and tied requesters
        write_id(1, 4'd9); write_id(2, 4'd9); write_id(3, 4'd12); write_id(0, 4'd3);
        check_case(lv4(0, 3, 0, 0), 3'd0, 3'd3, 1'b0);
        check("R9 new id used", int'(win_idx), 1);
        check_case(lv4(0, 3, 3, 0), 3'd0, 3'd3, 1'b0);
        check("R7 lowest tie", int'(win_idx), 1);
        // R6 external only, then external plus internal slot 0
        check_case(lv4(0, 0, 0, 0), 3'd7, 3'd7, 1'b0);
        check_case(lv4(7, 0, 0, 0), 3'd7, 3'd7, 1'b0);
        check_case(lv4(0, 7, 0, 0), 3'd7, 3'd7, 1'b0);
        // R8 acknowledge while busy
        check_case(lv4(0, 2, 2, 2), 3'd0, 3'd2, 1'b1);
        // sweep
        for (int t = 0; t < 400; t++) begin
            logic [N*LW-1:0] lv;
            for (int i = 0; i < N; i++) begin
                int unsigned r = rnd();
                write_id(i, (r % 5 == 0) ? 4'd0 : IW'(r % 6 + 10 * (r % 2)));
            end
            for (int i = 0; i < N; i++) lv[i*LW +: LW] = LW'(rnd() % 4);
            check_case(lv, LW'(rnd() % 4), LW'(rnd() % 4), t % 37 == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule